// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block sits beside an integer ALU and turns each finished operation into a set of condition flags. Each cycle it takes both source operands, the ALU result, the ALU carry out, a class code for the operation, the bit that a shift or rotate pushed out, and a width select for byte or word operands. From these it works out carry, parity, nibble carry, zero, sign and signed overflow. When the write enable is high, it stores them in a flags register.

Three control bits live in the same register: string direction, interrupt enable and single-step trap. A small command port sets or clears them one at a time, and the arithmetic write enable has no effect on them. The flags appear on the outputs one clock after the edge that captures them. Instruction sequencing logic and interrupt logic read these outputs directly.

Top module: `flag_keeper`

## Requirements
- R1: While reset is low, and on the first cycle after it goes high, all nine flag outputs are 0.
- R2: The zero flag becomes 1 when the result is zero over the selected width and 0 otherwise. With wideSel = 0 only the low 8 bits count. With wideSel = 1 all 16 bits count.
- R3: The sign flag takes result bit 7 when wideSel = 0 and result bit 15 when wideSel = 1.
- R4: The parity flag is 1 when the low 8 bits of the result hold an odd number of ones, and 0 when they hold an even number.
- R5: For add (opClass 0) and subtract (opClass 1), the nibble carry flag takes bit 4 of opA ^ opB ^ res. For logic (opClass 2) and shift (opClass 3) it is cleared.
- R6: The carry flag takes aluCarry for add and subtract, takes shiftBit for shift, and is cleared for logic.
- R7: On add, signed overflow is 1 exactly when both operands carry the same sign bit and the result's sign bit differs from it. The sign bit is bit 7 or bit 15, chosen by wideSel.
- R8: On subtract, signed overflow is 1 exactly when the operand sign bits differ and the result's sign bit differs from opA's. Logic and shift clear overflow.
- R9: Rotate (opClass 4) loads shiftBit into the carry flag and leaves the other five arithmetic flags unchanged.
- R10: With flagWe = 0 the six arithmetic flags keep their values whatever the other inputs are.
- R11: The opClass codes 5, 6 and 7 leave all six arithmetic flags unchanged even when flagWe = 1.
- R12: ctrlCmd codes: 1 sets direction, 2 clears direction, 3 sets interrupt enable, 4 clears interrupt enable, 5 sets trap, 6 clears trap. Codes 0 and 7 do nothing. The change is visible one clock later.
- R13: The control bits are changed only by ctrlCmd, and ctrlCmd changes no arithmetic flag. A command and an arithmetic write issued in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | 16 | First ALU operand |
| opB | input | 16 | Second ALU operand |
| res | input | 16 | ALU result |
| aluCarry | input | 1 | Carry or borrow out of the operand's top bit |
| opClass | input | 3 | 0 add, 1 sub, 2 logic, 3 shift, 4 rotate, 5-7 reserved |
| shiftBit | input | 1 | Last bit shifted or rotated out |
| wideSel | input | 1 | 0 byte operation, 1 word operation |
| flagWe | input | 1 | Arithmetic flag write enable |
| ctrlCmd | input | 3 | Control bit set/clear command |
| carryFlag | output | 1 | Carry flag |
| parityFlag | output | 1 | Odd parity of the low byte |
| nibbleCarryFlag | output | 1 | Carry from bit 3 into bit 4 |
| zeroFlag | output | 1 | Result is zero |
| signFlag | output | 1 | Result sign bit |
| overflowFlag | output | 1 | Signed overflow |
| dirFlag | output | 1 | String direction: 0 ascending, 1 descending |
| intEnFlag | output | 1 | 1 allows external interrupts, 0 masks them |
| trapFlag | output | 1 | Single-step trap enable |

## Verification
The bench uses the default widths: a 16-bit word and an 8-bit byte with the nibble boundary at bit 4. It can therefore drive the same operand patterns in both width modes. It uses a word whose high byte is nonzero but whose low byte is zero, to show that byte mode ignores the high byte for zero and sign. It uses a word whose low byte is zero, to show that parity looks at the low byte only. Because the word is twice the byte width, sign-bit overflow cases at bit 7 and at bit 15 are both reachable.

// File: rtl/flag_pkg.sv
package flag_pkg;

  localparam int NUM_CTL  = 3;
  localparam int CTL_DIR  = 0;
  localparam int CTL_IE   = 1;
  localparam int CTL_TRAP = 2;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_LOGIC  = 3'd2,
    OP_SHIFT  = 3'd3,
    OP_ROTATE = 3'd4
  } op_class_e;

  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_SET_DIR  = 3'd1,
    CMD_CLR_DIR  = 3'd2,
    CMD_SET_IE   = 3'd3,
    CMD_CLR_IE   = 3'd4,
    CMD_SET_TRAP = 3'd5,
    CMD_CLR_TRAP = 3'd6
  } ctl_cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               wrArith;      // load all six arithmetic flags
    logic               wrCarryOnly;  // load carry only (rotate)
    logic               arithOp;      // add or subtract
    logic               isSub;        // subtract rule for overflow
    logic               shiftOp;      // carry comes from shifted-out bit
    logic [NUM_CTL-1:0] setCtl;
    logic [NUM_CTL-1:0] clrCtl;
  } flag_strobe_t;

  typedef struct packed {
    logic carry;
    logic parity;
    logic nibble;
    logic zero;
    logic sign;
    logic ovf;
  } arith_flags_t;

endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic [2:0]   opClass,
  input  logic         flagWe,
  input  logic [2:0]   ctrlCmd,
  output flag_strobe_t strobe
);

  always_comb begin
    strobe = '0;
    unique case (opClass)
      OP_ADD: begin
        strobe.wrArith = flagWe;
        strobe.arithOp = 1'b1;
      end
      OP_SUB: begin
        strobe.wrArith = flagWe;
        strobe.arithOp = 1'b1;
        strobe.isSub   = 1'b1;
      end
      OP_LOGIC: begin
        strobe.wrArith = flagWe;
      end
      OP_SHIFT: begin
        strobe.wrArith = flagWe;
        strobe.shiftOp = 1'b1;
      end
      OP_ROTATE: begin
        strobe.wrCarryOnly = flagWe;
        strobe.shiftOp     = 1'b1;
      end
      default: ;
    endcase

    unique case (ctrlCmd)
      CMD_SET_DIR:  strobe.setCtl[CTL_DIR]  = 1'b1;
      CMD_CLR_DIR:  strobe.clrCtl[CTL_DIR]  = 1'b1;
      CMD_SET_IE:   strobe.setCtl[CTL_IE]   = 1'b1;
      CMD_CLR_IE:   strobe.clrCtl[CTL_IE]   = 1'b1;
      CMD_SET_TRAP: strobe.setCtl[CTL_TRAP] = 1'b1;
      CMD_CLR_TRAP: strobe.clrCtl[CTL_TRAP] = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  flag_strobe_t       strobe,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [DATA_W-1:0]  res,
  input  logic               aluCarry,
  input  logic               shiftBit,
  input  logic               wideSel,
  output arith_flags_t       arithQ,
  output logic [NUM_CTL-1:0] ctlQ
);

  localparam int WIDE_MSB   = DATA_W - 1;
  localparam int NARROW_MSB = BYTE_W - 1;
  localparam int NIB_BIT    = BYTE_W / 2;

  logic         msbA, msbB, msbR;
  logic         zeroRes;
  logic [DATA_W-1:0] halfSum;
  arith_flags_t arithD;

  always_comb begin
    msbA    = wideSel ? opA[WIDE_MSB] : opA[NARROW_MSB];
    msbB    = wideSel ? opB[WIDE_MSB] : opB[NARROW_MSB];
    msbR    = wideSel ? res[WIDE_MSB] : res[NARROW_MSB];
    zeroRes = wideSel ? (res == '0) : (res[NARROW_MSB:0] == '0);
    halfSum = opA ^ opB ^ res;

    arithD.zero   = zeroRes;
    arithD.sign   = msbR;
    arithD.parity = ^res[NARROW_MSB:0];
    arithD.nibble = strobe.arithOp & halfSum[NIB_BIT];

    if (strobe.arithOp)      arithD.carry = aluCarry;
    else if (strobe.shiftOp) arithD.carry = shiftBit;
    else                     arithD.carry = 1'b0;

    if (!strobe.arithOp)   arithD.ovf = 1'b0;
    else if (strobe.isSub) arithD.ovf = (msbA != msbB) && (msbR != msbA);
    else                   arithD.ovf = (msbA == msbB) && (msbR != msbA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arithQ <= '0;
    end else if (strobe.wrArith) begin
      arithQ <= arithD;
    end else if (strobe.wrCarryOnly) begin
      arithQ.carry <= arithD.carry;
    end
  end

  for (genvar gi = 0; gi < NUM_CTL; gi++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (!rstN)                   ctlQ[gi] <= 1'b0;
      else if (strobe.setCtl[gi])  ctlQ[gi] <= 1'b1;
      else if (strobe.clrCtl[gi])  ctlQ[gi] <= 1'b0;
    end
  end

endmodule

// File: rtl/flag_keeper.sv
module flag_keeper
  import flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] res,
  input  logic              aluCarry,
  input  logic [2:0]        opClass,
  input  logic              shiftBit,
  input  logic              wideSel,
  input  logic              flagWe,
  input  logic [2:0]        ctrlCmd,
  output logic              carryFlag,
  output logic              parityFlag,
  output logic              nibbleCarryFlag,
  output logic              zeroFlag,
  output logic              signFlag,
  output logic              overflowFlag,
  output logic              dirFlag,
  output logic              intEnFlag,
  output logic              trapFlag
);

  flag_strobe_t       strobe;
  arith_flags_t       arithQ;
  logic [NUM_CTL-1:0] ctlQ;

  flag_ctrl u_ctrl (
    .opClass (opClass),
    .flagWe  (flagWe),
    .ctrlCmd (ctrlCmd),
    .strobe  (strobe)
  );

  flag_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .res      (res),
    .aluCarry (aluCarry),
    .shiftBit (shiftBit),
    .wideSel  (wideSel),
    .arithQ   (arithQ),
    .ctlQ     (ctlQ)
  );

  assign carryFlag       = arithQ.carry;
  assign parityFlag      = arithQ.parity;
  assign nibbleCarryFlag = arithQ.nibble;
  assign zeroFlag        = arithQ.zero;
  assign signFlag        = arithQ.sign;
  assign overflowFlag    = arithQ.ovf;
  assign dirFlag         = ctlQ[CTL_DIR];
  assign intEnFlag       = ctlQ[CTL_IE];
  assign trapFlag        = ctlQ[CTL_TRAP];

endmodule

// File: rtl/flag_keeper_chk.sv
module flag_keeper_chk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] res,
  input logic [2:0]        opClass,
  input logic              shiftBit,
  input logic              wideSel,
  input logic              flagWe,
  input logic [2:0]        ctrlCmd,
  input logic              carryFlag,
  input logic              parityFlag,
  input logic              nibbleCarryFlag,
  input logic              zeroFlag,
  input logic              signFlag,
  input logic              overflowFlag,
  input logic              dirFlag,
  input logic              intEnFlag,
  input logic              trapFlag
);

  localparam int NARROW_MSB = BYTE_W - 1;

  // R10
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !flagWe |=> $stable({carryFlag, parityFlag, nibbleCarryFlag, zeroFlag, signFlag, overflowFlag}));

  // R6
  p_logic_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    flagWe && opClass == 3'd2 |=> !carryFlag && !overflowFlag && !nibbleCarryFlag);

  // R9
  p_rotate_r9: assert property (@(posedge clk) disable iff (!rstN)
    flagWe && opClass == 3'd4 |=> carryFlag == $past(shiftBit)
      && $stable({parityFlag, nibbleCarryFlag, zeroFlag, signFlag, overflowFlag}));

  // R4
  p_parity_r4: assert property (@(posedge clk) disable iff (!rstN)
    flagWe && opClass == 3'd0 |=> parityFlag == ^$past(res[NARROW_MSB:0]));

  // R7
  p_ovf_add_r7: assert property (@(posedge clk) disable iff (!rstN)
    flagWe && opClass == 3'd0 && !wideSel && opA[NARROW_MSB] == opB[NARROW_MSB]
      && res[NARROW_MSB] != opA[NARROW_MSB] |=> overflowFlag);

  // R12
  p_dir_set_r12: assert property (@(posedge clk) disable iff (!rstN)
    ctrlCmd == 3'd1 |=> dirFlag);

  // R13
  p_ctl_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    ctrlCmd == 3'd0 |=> $stable({dirFlag, intEnFlag, trapFlag}));

endmodule

bind flag_keeper flag_keeper_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .opA             (opA),
  .opB             (opB),
  .res             (res),
  .opClass         (opClass),
  .shiftBit        (shiftBit),
  .wideSel         (wideSel),
  .flagWe          (flagWe),
  .ctrlCmd         (ctrlCmd),
  .carryFlag       (carryFlag),
  .parityFlag      (parityFlag),
  .nibbleCarryFlag (nibbleCarryFlag),
  .zeroFlag        (zeroFlag),
  .signFlag        (signFlag),
  .overflowFlag    (overflowFlag),
  .dirFlag         (dirFlag),
  .intEnFlag       (intEnFlag),
  .trapFlag        (trapFlag)
);

// File: tb/test_flag_keeper.sv
`timescale 1ns/100ps
module test_flag_keeper;

  localparam int DW = 16;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] opA = '0, opB = '0, res = '0;
  logic          aluCarry = 1'b0, shiftBit = 1'b0, wideSel = 1'b0, flagWe = 1'b0;
  logic [2:0]    opClass = 3'd0, ctrlCmd = 3'd0;
  logic          carryFlag, parityFlag, nibbleCarryFlag, zeroFlag, signFlag;
  logic          overflowFlag, dirFlag, intEnFlag, trapFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // order: carry parity nibble zero sign ovf dir ie trap
  logic [8:0] expQ[$];
  string      tagQ[$];
  logic [8:0] model = '0;

  always #2.5 clk = ~clk;

  flag_keeper #(.DATA_W(DW), .BYTE_W(BW)) i_flag_keeper (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .res(res),
    .aluCarry(aluCarry), .opClass(opClass), .shiftBit(shiftBit),
    .wideSel(wideSel), .flagWe(flagWe), .ctrlCmd(ctrlCmd),
    .carryFlag(carryFlag), .parityFlag(parityFlag),
    .nibbleCarryFlag(nibbleCarryFlag), .zeroFlag(zeroFlag),
    .signFlag(signFlag), .overflowFlag(overflowFlag),
    .dirFlag(dirFlag), .intEnFlag(intEnFlag), .trapFlag(trapFlag)
  );

  function automatic logic [8:0] observed();
    return {carryFlag, parityFlag, nibbleCarryFlag, zeroFlag, signFlag,
            overflowFlag, dirFlag, intEnFlag, trapFlag};
  endfunction

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected flags
  task automatic drive(input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [DW-1:0] r, input logic c, input logic [2:0] op,
                       input logic sb, input logic w, input logic we,
                       input logic [2:0] cmd, input string tag);
    logic [8:0] n;
    int msb;
    logic ma, mb, mr;
    @(negedge clk);
    opA = a; opB = b; res = r; aluCarry = c; opClass = op;
    shiftBit = sb; wideSel = w; flagWe = we; ctrlCmd = cmd;
    n = model;
    msb = w ? DW-1 : BW-1;
    ma = a[msb]; mb = b[msb]; mr = r[msb];
    if (we && op <= 3'd3) begin
      n[8] = (op <= 3'd1) ? c : (op == 3'd3 ? sb : 1'b0);
      n[7] = ^r[BW-1:0];
      n[6] = (op <= 3'd1) ? (a[4] ^ b[4] ^ r[4]) : 1'b0;
      n[5] = w ? (r == 0) : (r[BW-1:0] == 0);
      n[4] = mr;
      if (op == 3'd0)      n[3] = (ma == mb) && (mr != ma);
      else if (op == 3'd1) n[3] = (ma != mb) && (mr != ma);
      else                 n[3] = 1'b0;
    end else if (we && op == 3'd4) begin
      n[8] = sb;
    end
    case (cmd)
      3'd1: n[2] = 1'b1;
      3'd2: n[2] = 1'b0;
      3'd3: n[1] = 1'b1;
      3'd4: n[1] = 1'b0;
      3'd5: n[0] = 1'b1;
      3'd6: n[0] = 1'b0;
      default: ;
    endcase
    model = n;
    expQ.push_back(n);
    tagQ.push_back(tag);
  endtask

  // monitor: pops one expected item per captured cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) check(observed(), expQ.pop_front(), tagQ.pop_front());
    end
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(observed(), 9'b0, "R1 during reset");
    rstN = 1'b1;
    @(posedge clk); #1;
    check(observed(), 9'b0, "R1 after reset");

    // byte add 0x7F+0x01: sign, overflow, nibble carry, odd parity
    drive(16'h007F, 16'h0001, 16'h0080, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0, "R7 add overflow");
    // byte add wraps to zero, high byte nonzero ignored
    drive(16'h00FF, 16'h0001, 16'hAB00, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0, "R2 byte zero");
    // same result as word: not zero, sign from bit 15
    drive(16'h00FF, 16'h0001, 16'hAB00, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 3'd0, "R3 word sign");
    // word add 0x8000+0x8000
    drive(16'h8000, 16'h8000, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 3'd0, "R6 word carry");
    // byte sub 0x80-0x01 overflow
    drive(16'h0080, 16'h0001, 16'h007F, 1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 3'd0, "R8 sub overflow");
    // byte sub 0x05-0x03 no overflow, borrow into nibble none
    drive(16'h0005, 16'h0003, 16'h0002, 1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 3'd0, "R5 sub nibble");
    // sub 0x10-0x01 borrow from bit 4
    drive(16'h0010, 16'h0001, 16'h000F, 1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 3'd0, "R5 sub borrow");
    // logic: clears carry/overflow/nibble, even parity
    drive(16'h00F3, 16'h000F, 16'h0003, 1'b1, 3'd2, 1'b1, 1'b0, 1'b1, 3'd0, "R6 logic clear");
    // parity odd on low byte
    drive(16'h0000, 16'h0000, 16'h0007, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 3'd0, "R4 odd parity");
    // shift word: carry from shiftBit, parity of zero low byte
    drive(16'h0080, 16'h0001, 16'h0100, 1'b0, 3'd3, 1'b1, 1'b1, 1'b1, 3'd0, "R6 shift carry");
    // rotate: only carry changes
    drive(16'h0000, 16'h0000, 16'h0000, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 3'd0, "R9 rotate");
    drive(16'h0000, 16'h0000, 16'hFFFF, 1'b0, 3'd4, 1'b1, 1'b1, 1'b1, 3'd0, "R9 rotate set");
    // write enable low: hold
    drive(16'h007F, 16'h0001, 16'h0080, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, "R10 hold");
    // reserved class: hold
    drive(16'h007F, 16'h0001, 16'h0000, 1'b0, 3'd6, 1'b0, 1'b0, 1'b1, 3'd0, "R11 reserved");
    drive(16'h0000, 16'h0000, 16'h0000, 1'b0, 3'd5, 1'b0, 1'b0, 1'b1, 3'd0, "R11 reserved5");
    // control commands, no arithmetic write
    drive(16'h0000, 16'h0000, 16'h0000, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd1, "R12 set dir");
    drive(16'h0000, 16'h0000, 16'h0000, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd3, "R12 set ie");
    drive(16'h0000, 16'h0000, 16'h0000, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd5, "R12 set trap");
    drive(16'h0000, 16'h0000, 16'h0000, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd7, "R12 nop code");
    drive(16'h0000, 16'h0000, 16'h0000, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd2, "R12 clr dir");
    // arithmetic write with no command keeps control bits
    drive(16'h0001, 16'h0001, 16'h0002, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0, "R13 arith only");
    // both at once
    drive(16'h0000, 16'h0000, 16'h0000, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 3'd4, "R13 combined");
    drive(16'h0000, 16'h0000, 16'h0000, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd6, "R12 clr trap");
    drive(16'h0000, 16'h0000, 16'h0000, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, "R13 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule